// File: doc/BRIEF.md
# Handshaked Serial Byte Link (Host Side)

This block is the host end of a byte-wide serial channel to a power-management microcontroller. The remote device drives the serial clock. Every byte is framed by two active-low handshake wires: the host pulls its request line low to start a byte, and the remote answers on an acknowledge line. A transfer begins with a one-cycle start pulse. In send direction the byte is loaded and shifted out MSB first. In receive direction the shift register is cleared and incoming bits are gathered MSB first. In both directions the register advances on synchronized rising edges of the remote clock.

After the eighth edge the block releases the request line and waits for the acknowledge line to return high. It then pulses a completion strobe. If acknowledge stays low for a configurable number of cycles, the block abandons the transfer and reports it with the error bit set. Two event flags, shift-complete and remote-clock transition, each carry an enable and are cleared by writing 1. Together they drive a single interrupt line. All remote inputs pass through a synchronizer chain before use.

Top module: `hs_byte_link`

## Requirements
- R1: After reset, req_n is 1, shift_mode is 3'b000, busy is 0, xfer_done is 0, both flags are 0 and irq is 0.
- R2: A tx_start pulse while idle sets shift_mode to 3'b111 and drives req_n low. The byte is then presented on sdo MSB first, and sdo moves to the next bit after each synchronized rising edge of sclk.
- R3: An rx_start pulse while idle (with tx_start low) sets shift_mode to 3'b011 and drives req_n low. sdi is sampled on each synchronized rising sclk edge, MSB first, and the assembled byte appears on rx_byte when xfer_done pulses.
- R4: The eighth synchronized rising sclk edge of a transfer negates req_n and sets flags[0] (shift complete).
- R5: Once req_n is negated, a synchronized high level on ack_n produces a one-cycle xfer_done pulse with xfer_err 0, and the block returns to idle.
- R6: If ack_n stays low for TIMEOUT_CYC cycles after req_n is negated, xfer_done pulses with xfer_err 1.
- R7: ack_warn pulses for one cycle when ack_n is already high at the moment the shift completes. It never pulses when ack_n is low at that moment.
- R8: Every transition of the synchronized sclk, in any state, sets flags[1].
- R9: A 1 in flag_clr clears the matching flag bit; a 0 leaves it unchanged.
- R10: irq is high exactly when some flag bit is set and its flag_en bit is 1.
- R11: tx_start and rx_start are ignored while busy is 1. Neither the shift direction nor the byte being assembled changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Start a send of tx_byte |
| tx_byte | input | BYTE_W | Byte to send |
| rx_start | input | 1 | Start a receive |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion strobe |
| xfer_err | output | 1 | Last transfer ended by timeout |
| ack_warn | output | 1 | Acknowledge was high at shift completion |
| rx_byte | output | BYTE_W | Last received byte |
| shift_mode | output | 3 | Shift mode: 000 off, 011 external-clock in, 111 out |
| req_n | output | 1 | Active-low request to remote |
| ack_n | input | 1 | Active-low acknowledge from remote |
| sclk | input | 1 | Remote-driven shift clock |
| sdi | input | 1 | Serial data from remote |
| sdo | output | 1 | Serial data to remote |
| flag_clr | input | 2 | Write-1-to-clear for the flags |
| flag_en | input | 2 | Interrupt enables |
| flags | output | 2 | Bit 0 shift complete, bit 1 clock transition |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps the default byte width and synchronizer depth and lowers TIMEOUT_CYC to 40. The short timeout lets the abandoned-transfer path be timed to the cycle inside a short run. It also leaves room to sweep all 256 byte values in both directions, with the bench acting as the remote device. Single scenarios cover the early-acknowledge warning, a start issued in the middle of a byte, and each flag enable and clear combination.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_RELEASE = 2'd2
    } link_state_e;

    localparam logic [2:0] MODE_OFF    = 3'b000;
    localparam logic [2:0] MODE_EXT_IN = 3'b011;
    localparam logic [2:0] MODE_OUT    = 3'b111;

    localparam int FLAG_SHIFT = 0;
    localparam int FLAG_EDGE  = 1;
    localparam int NUM_FLAGS  = 2;

    typedef struct packed {
        logic clk_edge;
        logic shift_done;
    } link_evt_t;

    function automatic logic mode_is_out(input logic [2:0] m);
        return m[2];
    endfunction

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
    parameter int         STAGES  = 2,
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[i] <= RST_VAL;
                else if (i == 0)
                    stg[i] <= d;
                else
                    stg[i] <= stg[(i > 0) ? i - 1 : 0];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsl_shifter.sv
module hsl_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_tx,
    input  logic              load_rx,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              active,
    input  logic              dir_out,
    input  logic              rise,
    input  logic              din,
    output logic              dout,
    output logic [BYTE_W-1:0] sr_q,
    output logic              sh_done
);
    localparam int CW = $clog2(BYTE_W + 1);

    logic [CW-1:0] cnt;
    logic          last;

    assign last    = (cnt == CW'(BYTE_W - 1));
    assign sh_done = active && rise && last;
    assign dout    = dir_out & sr_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            cnt  <= '0;
        end else if (load_tx) begin
            sr_q <= tx_data;
            cnt  <= '0;
        end else if (load_rx) begin
            sr_q <= '0;
            cnt  <= '0;
        end else if (active && rise) begin
            sr_q <= {sr_q[BYTE_W-2:0], dir_out ? 1'b0 : din};
            cnt  <= last ? '0 : cnt + 1'b1;
        end
    end

    p_bitcnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(BYTE_W));
endmodule

// File: rtl/hsl_ctrl.sv
module hsl_ctrl
    import hsl_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int TIMEOUT_CYC = 32000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic              rx_start,
    input  logic              sh_done,
    input  logic              ack_s,
    input  logic [BYTE_W-1:0] sr_q,
    output logic              load_tx,
    output logic              load_rx,
    output logic              shifting,
    output logic              busy,
    output logic              req_n,
    output logic [2:0]        mode,
    output logic              done,
    output logic              err,
    output logic              warn,
    output logic [BYTE_W-1:0] rx_q
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    link_state_e   st;
    logic [TW-1:0] timer;
    logic          expire;

    assign load_tx  = (st == ST_IDLE) && tx_start;
    assign load_rx  = (st == ST_IDLE) && rx_start && !tx_start;
    assign shifting = (st == ST_SHIFT);
    assign busy     = (st != ST_IDLE);
    assign expire   = (timer == TW'(TIMEOUT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            req_n <= 1'b1;
            mode  <= MODE_OFF;
            done  <= 1'b0;
            err   <= 1'b0;
            warn  <= 1'b0;
            timer <= '0;
            rx_q  <= '0;
        end else begin
            done <= 1'b0;
            warn <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (load_tx) begin
                        mode  <= MODE_OUT;
                        req_n <= 1'b0;
                        st    <= ST_SHIFT;
                    end else if (load_rx) begin
                        mode  <= MODE_EXT_IN;
                        req_n <= 1'b0;
                        st    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        req_n <= 1'b1;
                        warn  <= ack_s;
                        timer <= '0;
                        st    <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (ack_s || expire) begin
                        done <= 1'b1;
                        err  <= !ack_s;
                        st   <= ST_IDLE;
                        if (!mode_is_out(mode))
                            rx_q <= sr_q;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    p_start_drops_req_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && (tx_start || rx_start)) |=> !req_n);
    p_done_released_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> req_n);
    p_timer_bound_r6: assert property (@(posedge clk) disable iff (rst)
        timer < TW'(TIMEOUT_CYC));
    p_warn_released_r7: assert property (@(posedge clk) disable iff (rst)
        warn |-> (req_n && busy));
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && $past(busy)) |-> $stable(mode));
endmodule

// File: rtl/hsl_irq.sv
module hsl_irq
    import hsl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  link_evt_t            evt,
    input  logic [NUM_FLAGS-1:0] clr,
    input  logic [NUM_FLAGS-1:0] en,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] set_v;

    assign set_v[FLAG_SHIFT] = evt.shift_done;
    assign set_v[FLAG_EDGE]  = evt.clk_edge;
    assign irq               = |(flags & en);

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr) | set_v;
    end

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
            p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (flags[i] && !clr[i]) |=> flags[i]);
            p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !set_v[i]) |=> !flags[i]);
        end
    endgenerate
endmodule

// File: rtl/hs_byte_link.sv
module hs_byte_link
    import hsl_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 32000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_start,
    output logic              busy,
    output logic              xfer_done,
    output logic              xfer_err,
    output logic              ack_warn,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [2:0]        shift_mode,
    output logic              req_n,
    input  logic              ack_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    input  logic [1:0]        flag_clr,
    input  logic [1:0]        flag_en,
    output logic [1:0]        flags,
    output logic              irq
);
    logic [2:0]        sync_q;
    logic              sclk_s, sdi_s, ack_s, sclk_prev;
    logic              load_tx, load_rx, shifting, sh_done;
    logic [BYTE_W-1:0] sr_q;
    link_evt_t         evt;

    hsl_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d({ack_n, sdi, sclk}), .q(sync_q)
    );
    assign {ack_s, sdi_s, sclk_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= sclk_s;
    end

    hsl_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst), .load_tx(load_tx), .load_rx(load_rx),
        .tx_data(tx_byte), .active(shifting), .dir_out(mode_is_out(shift_mode)),
        .rise(sclk_s && !sclk_prev), .din(sdi_s), .dout(sdo),
        .sr_q(sr_q), .sh_done(sh_done)
    );

    hsl_ctrl #(.BYTE_W(BYTE_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .tx_start(tx_start), .rx_start(rx_start),
        .sh_done(sh_done), .ack_s(ack_s), .sr_q(sr_q),
        .load_tx(load_tx), .load_rx(load_rx), .shifting(shifting), .busy(busy),
        .req_n(req_n), .mode(shift_mode), .done(xfer_done), .err(xfer_err),
        .warn(ack_warn), .rx_q(rx_byte)
    );

    assign evt.shift_done = sh_done;
    assign evt.clk_edge   = sclk_s ^ sclk_prev;

    hsl_irq u_irq (
        .clk(clk), .rst(rst), .evt(evt), .clr(flag_clr), .en(flag_en),
        .flags(flags), .irq(irq)
    );
endmodule

// File: tb/sim_hs_byte_link.sv
module sim_hs_byte_link;
    localparam int TO = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_start = 1'b0, rx_start = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       busy, xfer_done, xfer_err, ack_warn, req_n, sdo, irq;
    logic [7:0] rx_byte;
    logic [2:0] shift_mode;
    logic       ack_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [1:0] flag_clr = '0, flag_en = '0, flags;

    int total = 0, fails = 0;
    int cyc = 0, rel_cyc = 0, done_cyc = 0, done_cnt = 0, warn_cnt = 0;
    logic req_prev = 1'b1, last_err = 1'b0;

    always #2 clk = ~clk;

    hs_byte_link #(.TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst(rst), .tx_start(tx_start), .tx_byte(tx_byte),
        .rx_start(rx_start), .busy(busy), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .ack_warn(ack_warn), .rx_byte(rx_byte),
        .shift_mode(shift_mode), .req_n(req_n), .ack_n(ack_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .flag_clr(flag_clr), .flag_en(flag_en),
        .flags(flags), .irq(irq)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (req_n && !req_prev) rel_cyc = cyc;
        req_prev = req_n;
        if (xfer_done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
            last_err = xfer_err;
        end
        if (ack_warn) warn_cnt = warn_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bench plays the remote device. mode: 0 normal, 1 ack early high, 2 never ack
    task automatic xfer(input bit is_tx, input logic [7:0] b, input int kind, input bit poke);
        logic [7:0] got = '0;
        int start_done = done_cnt;
        @(negedge clk);
        tx_byte  = b;
        tx_start = is_tx;
        rx_start = !is_tx;
        @(negedge clk);
        tx_start = 1'b0;
        rx_start = 1'b0;
        for (int k = 0; k < 20 && req_n; k++) @(negedge clk);
        chk(!req_n, is_tx ? "R2" : "R3", req_n, 0);
        chk(shift_mode == (is_tx ? 3'b111 : 3'b011), is_tx ? "R2" : "R3",
            shift_mode, is_tx ? 7 : 3);
        ack_n = (kind == 1);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            tick(3);
            got = {got[6:0], sdo};
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            if (poke && i == 4) begin
                tx_byte  = ~b;
                tx_start = 1'b1;
                rx_start = 1'b1;
                @(negedge clk);
                tx_start = 1'b0;
                rx_start = 1'b0;
                chk(busy && shift_mode == 3'b011, "R11", shift_mode, 3);
                tick(2);
            end else begin
                tick(3);
            end
        end
        for (int k = 0; k < 20 && !req_n; k++) @(negedge clk);
        chk(req_n == 1'b1, "R4", req_n, 1);
        chk(flags[0] == 1'b1, "R4", flags, 1);
        if (kind == 0) begin
            tick(2);
            ack_n = 1'b1;
        end
        for (int k = 0; k < TO + 20 && done_cnt == start_done; k++) @(negedge clk);
        chk(done_cnt == start_done + 1, "R5", done_cnt - start_done, 1);
        if (kind == 2) begin
            chk(last_err == 1'b1, "R6", last_err, 1);
            chk(done_cyc - rel_cyc >= TO && done_cyc - rel_cyc <= TO + 1, "R6",
                done_cyc - rel_cyc, TO);
        end else begin
            chk(last_err == 1'b0, "R5", last_err, 0);
        end
        if (is_tx) chk(got == b, "R2", got, b);
        else       chk(rx_byte == b, "R3", rx_byte, b);
        ack_n = 1'b1;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_n == 1'b1 && busy == 1'b0 && xfer_done == 1'b0, "R1",
            {req_n, busy, xfer_done}, 3'b100);
        chk(shift_mode == 3'b000, "R1", shift_mode, 0);
        chk(flags == 2'b00 && irq == 1'b0, "R1", {flags, irq}, 0);

        // R8, R10, R9: clock-edge flag while idle
        sclk = 1'b1;
        tick(5);
        chk(flags == 2'b10, "R8", flags, 2);
        flag_en = 2'b01;
        @(negedge clk);
        chk(irq == 1'b0, "R10", irq, 0);
        flag_en = 2'b10;
        @(negedge clk);
        chk(irq == 1'b1, "R10", irq, 1);
        flag_clr = 2'b01;
        @(negedge clk);
        flag_clr = 2'b00;
        @(negedge clk);
        chk(flags == 2'b10, "R9", flags, 2);
        flag_clr = 2'b10;
        @(negedge clk);
        flag_clr = 2'b00;
        @(negedge clk);
        chk(flags == 2'b00 && irq == 1'b0, "R9", {flags, irq}, 0);
        sclk = 1'b0;
        tick(5);
        chk(flags == 2'b10, "R8", flags, 2);
        flag_en = 2'b01;
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;

        // Sweep all bytes both directions
        for (int v = 0; v < 256; v++) xfer(1'b1, 8'(v), 0, 1'b0);
        for (int v = 0; v < 256; v++) xfer(1'b0, 8'(v), 0, 1'b0);
        chk(warn_cnt == 0, "R7", warn_cnt, 0);
        chk(flags[0] == 1'b1 && irq == 1'b1, "R10", {flags, irq}, 3);

        // R11 start while busy, R7 early ack, R6 timeout
        xfer(1'b0, 8'hA5, 0, 1'b1);
        xfer(1'b1, 8'h3C, 1, 1'b0);
        chk(warn_cnt == 1, "R7", warn_cnt, 1);
        xfer(1'b1, 8'h96, 2, 1'b0);
        xfer(1'b0, 8'h5A, 2, 1'b0);
        chk(warn_cnt == 1, "R7", warn_cnt, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule